// File: doc/BRIEF.md
# Gated 16-bit Event Timer with Comparator Gate Synchronizer

This block counts edges of a slow timer clock. The timer clock is sampled as a level signal in the system-clock domain and divided by 1, 2, 4 or 8. The counter steps once for each rising edge of the divided clock. Counting can be gated by an active-high gate signal. That gate comes either from an external gate pin or from the output of a second comparator. The comparator path can be resampled on the falling edge of the divided clock. With the resampling on, a gate change can never coincide with a count step. This makes the block suited to measuring how long an analog condition lasts.

An 8-bit control register holds the gate-source select and the resampling enable. It also carries registered copies of both comparator outputs, so software reads them together in a single access. The register has no read strobe, so reading it never changes any state.

Top module: `cmp_gated_timer`

## Requirements
- R1: After reset the count is 0, the overflow output is 0 and the register reads 0x02 (source select = 1, resample enable = 0, mirror bits = 0).
- R2: A register write stores only bit 1 (gate source select) and bit 0 (comparator resample enable). Bits 5..2 always read 0, and bits 7..6 cannot be written.
- R3: Register bit 7 reads comparator 1 and bit 6 reads comparator 2, one system clock after the inputs change.
- R4: While the timer enable is low, the count holds and the divider is cleared to zero.
- R5: The divider field value k (0..3) selects a ratio of 1:2^k. From a cleared divider, n raw rising edges give (n + h) >> k count steps, where h = 2^(k-1) for k > 0 and h = 0 for k = 0.
- R6: With gating disabled, the count steps once on every rising edge of the divided clock, whatever the gate level, and never by more than one per cycle.
- R7: With gating enabled and select = 1, a rising edge steps the count only while the external gate pin is high.
- R8: With gating enabled, select = 0 and resample enable = 0, a rising edge steps the count only while comparator 2 is high at that edge.
- R9: With resample enable = 1, comparator 2 is captured at each falling edge of the divided clock. A rising edge then uses the value captured at the previous falling edge, and later changes are ignored until the next falling edge.
- R10: The count wraps from 0xFFFF to 0x0000, and the overflow output is high for exactly one cycle at that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tclk_i | input | 1 | Raw timer clock level, synchronous to clk_i |
| ps_sel_i | input | 2 | Divider ratio select, 1:2^value |
| ton_i | input | 1 | Timer enable |
| gate_en_i | input | 1 | Gate control enable |
| cmp1_i | input | 1 | Comparator 1 output |
| cmp2_i | input | 1 | Comparator 2 output |
| gate_pin_i | input | 1 | External gate pin |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register read data |
| count_o | output | 16 | Current count |
| ovf_o | output | 1 | One-cycle overflow pulse |

## Verification
The assertions check several properties on every cycle:
- the count holds while the timer is off or while the gate blocks it;
- the count never moves by more than one per cycle;
- the overflow pulse only appears with a zero count;
- the resampled comparator value changes only on a falling strobe;
- the divider is empty after the timer is switched off;
- the reserved bits read zero and the mirrors track the inputs.

Only the bench's scenarios show the things that depend on sequences of events. These are the step ratio for each divider setting, the difference between the live and the resampled comparator gate, and the wrap after a full 65536-step run.

// File: rtl/cgt_pkg.sv
package cgt_pkg;
    localparam int CTRL_W   = 8;
    localparam int PS_W     = 2;
    localparam int MIR1_BIT = 7;
    localparam int MIR2_BIT = 6;
    localparam int SEL_BIT  = 1;
    localparam int SYNC_BIT = 0;
endpackage

// File: rtl/cgt_prescale.sv
module cgt_prescale #(
    parameter int PS_W = 2
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            tclk_i,
    input  logic            ton_i,
    input  logic [PS_W-1:0] ps_sel_i,
    output logic            rise_o,
    output logic            fall_o
);
    localparam int DIV_W = (1 << PS_W) - 1;

    typedef struct packed {
        logic             tclk;
        logic [DIV_W-1:0] div;
        logic             pclk;
    } ps_state_t;

    ps_state_t s_d, s_q;
    logic [DIV_W:0] taps;
    logic           raw_rise;

    always_comb begin
        s_d      = s_q;
        raw_rise = tclk_i & ~s_q.tclk;
        s_d.tclk = tclk_i;
        if (!ton_i) begin
            s_d.div = '0;
        end else if (raw_rise) begin
            s_d.div = s_q.div + 1'b1;
        end
        // tap 0 is the undivided clock, tap k is divider bit k-1
        taps     = {s_d.div, tclk_i};
        s_d.pclk = taps[ps_sel_i];
        rise_o   = s_d.pclk & ~s_q.pclk;
        fall_o   = ~s_d.pclk & s_q.pclk;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    AST_DIV_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ton_i |=> (s_q.div == '0)); // R4

    AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({rise_o, fall_o})); // R5
endmodule

// File: rtl/cgt_gate_sync.sv
module cgt_gate_sync (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fall_i,
    input  logic cmp2_i,
    input  logic sync_en_i,
    input  logic sel_pin_i,
    input  logic gate_pin_i,
    output logic gate_o
);
    typedef struct packed {
        logic c2s;
    } gs_state_t;

    gs_state_t s_d, s_q;
    logic      cmp_path;

    always_comb begin
        s_d = s_q;
        if (fall_i) s_d.c2s = cmp2_i;
        cmp_path = sync_en_i ? s_q.c2s : cmp2_i;
        gate_o   = sel_pin_i ? gate_pin_i : cmp_path;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    AST_SYNC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fall_i |=> $stable(s_q.c2s)); // R9

    AST_SYNC_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_i |=> (s_q.c2s == $past(cmp2_i))); // R9
endmodule

// File: rtl/cgt_counter.sv
module cgt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ton_i,
    input  logic             rise_i,
    input  logic             gate_en_i,
    input  logic             gate_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } ct_state_t;

    ct_state_t s_d, s_q;
    logic      step;

    always_comb begin
        s_d     = s_q;
        step    = ton_i & rise_i & (~gate_en_i | gate_i);
        s_d.ovf = step & (&s_q.cnt);
        if (step) s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign count_o = s_q.cnt;
    assign ovf_o   = s_q.ovf;

    AST_OVF_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |-> (count_o == '0)); // R10

    AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ton_i |=> $stable(count_o)); // R4

    AST_GATE_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gate_en_i && !gate_i) |=> $stable(count_o)); // R7

    AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $stable(count_o) || (count_o == $past(count_o) + 1'b1)); // R6
endmodule

// File: rtl/cgt_ctrl_reg.sv
module cgt_ctrl_reg
    import cgt_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [CTRL_W-1:0] wdata_i,
    input  logic              cmp1_i,
    input  logic              cmp2_i,
    output logic [CTRL_W-1:0] rdata_o,
    output logic              sel_pin_o,
    output logic              sync_en_o
);
    typedef struct packed {
        logic       sel;
        logic       sync;
        logic [1:0] mir;
    } rg_state_t;

    rg_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.mir = {cmp1_i, cmp2_i};
        if (we_i) begin
            s_d.sel  = wdata_i[SEL_BIT];
            s_d.sync = wdata_i[SYNC_BIT];
        end
        rdata_o           = '0;
        rdata_o[MIR1_BIT] = s_q.mir[1];
        rdata_o[MIR2_BIT] = s_q.mir[0];
        rdata_o[SEL_BIT]  = s_q.sel;
        rdata_o[SYNC_BIT] = s_q.sync;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{sel: 1'b1, sync: 1'b0, mir: 2'b00};
        else         s_q <= s_d;
    end

    assign sel_pin_o = s_q.sel;
    assign sync_en_o = s_q.sync;

    AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rdata_o[5:2] == 4'b0000); // R2

    AST_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (rdata_o[MIR1_BIT] == $past(cmp1_i)) && (rdata_o[MIR2_BIT] == $past(cmp2_i))); // R3
endmodule

// File: rtl/cmp_gated_timer.sv
module cmp_gated_timer
    import cgt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tclk_i,
    input  logic [PS_W-1:0]   ps_sel_i,
    input  logic              ton_i,
    input  logic              gate_en_i,
    input  logic              cmp1_i,
    input  logic              cmp2_i,
    input  logic              gate_pin_i,
    input  logic              reg_we_i,
    input  logic [CTRL_W-1:0] reg_wdata_i,
    output logic [CTRL_W-1:0] reg_rdata_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              ovf_o
);
    logic rise, fall, gate, sel_pin, sync_en;

    cgt_prescale #(.PS_W(PS_W)) u_ps (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tclk_i   (tclk_i),
        .ton_i    (ton_i),
        .ps_sel_i (ps_sel_i),
        .rise_o   (rise),
        .fall_o   (fall)
    );

    cgt_ctrl_reg u_reg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .we_i      (reg_we_i),
        .wdata_i   (reg_wdata_i),
        .cmp1_i    (cmp1_i),
        .cmp2_i    (cmp2_i),
        .rdata_o   (reg_rdata_o),
        .sel_pin_o (sel_pin),
        .sync_en_o (sync_en)
    );

    cgt_gate_sync u_gs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .fall_i     (fall),
        .cmp2_i     (cmp2_i),
        .sync_en_i  (sync_en),
        .sel_pin_i  (sel_pin),
        .gate_pin_i (gate_pin_i),
        .gate_o     (gate)
    );

    cgt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ton_i     (ton_i),
        .rise_i    (rise),
        .gate_en_i (gate_en_i),
        .gate_i    (gate),
        .count_o   (count_o),
        .ovf_o     (ovf_o)
    );
endmodule

// File: tb/sim_cmp_gated_timer.sv
module sim_cmp_gated_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tclk = 1'b0;
    logic [1:0]  ps = 2'd0;
    logic        ton = 1'b0, gen = 1'b0, c1 = 1'b0, c2 = 1'b0, gpin = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic [15:0] count;
    logic        ovf;

    int total = 0;
    int bad = 0;
    int ovf_seen = 0;
    int ovf_long = 0;
    bit ovf_prev = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_gated_timer u0 (
        .clk_i(clk), .rst_ni(rst_n), .tclk_i(tclk), .ps_sel_i(ps), .ton_i(ton),
        .gate_en_i(gen), .cmp1_i(c1), .cmp2_i(c2), .gate_pin_i(gpin),
        .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .count_o(count), .ovf_o(ovf)
    );

    always @(negedge clk) begin
        if (ovf) begin
            ovf_seen++;
            if (ovf_prev) ovf_long++;
        end
        ovf_prev = ovf;
    end

    function automatic int exp_steps(int n, int k);
        int h;
        h = (k == 0) ? 0 : (1 << (k - 1));
        return (n + h) >> k;
    endfunction

    task automatic chk(string req, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int hi, int lo);
        tclk = 1'b1;
        repeat (hi) @(negedge clk);
        tclk = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] v);
        we = 1'b1; wdata = v;
        @(negedge clk);
        we = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int base, n, expn, prev;
        bit v;
        void'($urandom(32'h0000_5eed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 count", count, 0);
        chk("R1 ovf", ovf, 0);
        chk("R1 reg", rdata, 8'h02);

        // R2 write masking
        wr(8'hFF);
        chk("R2 write ff", rdata, 8'h03);
        wr(8'h3C);
        chk("R2 write 3c", rdata, 8'h00);

        // R3 mirrors
        for (int i = 0; i < 4; i++) begin
            c1 = i[1]; c2 = i[0];
            @(negedge clk);
            chk("R3 mirror", rdata[7:6], i[1:0]);
        end
        c1 = 1'b0; c2 = 1'b0;

        // R5 divider ratios from a cleared divider
        for (int k = 0; k < 4; k++) begin
            ton = 1'b0; ps = k[1:0];
            repeat (3) @(negedge clk);
            ton = 1'b1;
            @(negedge clk);
            base = count;
            n = 5 + int'($urandom_range(15));
            for (int j = 0; j < n; j++) tick(2, 2);
            chk("R5 ratio", count, base + exp_steps(n, k));
        end

        // R4 timer off holds the count
        ton = 1'b0; ps = 2'd0;
        @(negedge clk);
        base = count;
        for (int j = 0; j < 6; j++) tick(1, 2);
        chk("R4 off hold", count, base);
        ton = 1'b1;
        @(negedge clk);

        // R6 gate disabled, gate levels random
        gen = 1'b0; wr(8'h02);
        base = count;
        n = 12;
        for (int j = 0; j < n; j++) begin
            gpin = 1'($urandom_range(1)); c2 = 1'($urandom_range(1));
            tick(1, 2);
        end
        chk("R6 ungated", count, base + n);

        // R7 gate pin
        gen = 1'b1; wr(8'h02);
        base = count; expn = 0;
        for (int j = 0; j < 20; j++) begin
            v = 1'($urandom_range(1));
            gpin = v; c2 = ~v;
            expn += int'(v);
            tick(2, 2);
        end
        chk("R7 pin gate", count, base + expn);

        // R8 live comparator 2
        wr(8'h00);
        base = count; expn = 0;
        for (int j = 0; j < 20; j++) begin
            v = 1'($urandom_range(1));
            c2 = v; gpin = ~v;
            expn += int'(v);
            tick(2, 3);
        end
        chk("R8 live cmp", count, base + expn);

        // R9 resampled comparator 2: prime captured value with 0
        wr(8'h01);
        gen = 1'b0; c2 = 1'b0;
        tick(2, 3);
        gen = 1'b1;
        base = count; expn = 0; prev = 0;
        for (int j = 0; j < 20; j++) begin
            v = 1'($urandom_range(1));
            c2 = v;
            expn += prev;
            prev = int'(v);
            tick(2, 3);
        end
        chk("R9 resampled", count, base + expn);
        // directed: raise c2 after a captured 0, rising edge must not step
        c2 = 1'b0; gen = 1'b0;
        tick(2, 3);
        gen = 1'b1; c2 = 1'b1;
        base = count;
        tick(2, 3);
        chk("R9 late change ignored", count, base);
        tick(2, 3);
        chk("R9 captured one", count, base + 1);

        // R10 wrap with one-cycle overflow
        gen = 1'b0; c2 = 1'b0;
        wr(8'h02);
        ovf_seen = 0; ovf_long = 0;
        n = 65536 - int'(count);
        for (int j = 0; j < n; j++) tick(1, 1);
        @(negedge clk);
        chk("R10 wrap count", count, 0);
        chk("R10 ovf pulses", ovf_seen, 1);
        chk("R10 ovf width", ovf_long, 0);
        tick(1, 2);
        chk("R10 after wrap", count, 1);
        chk("R10 ovf low", ovf, 0);

        finish_run();
    end
endmodule